// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural register state of a 32-bit processor core whose register set is partly duplicated per operating mode. Sixteen general registers and a current status word are always visible. The low five bits of the current status word name the mode, and that mode decides which physical copy answers for the banked indices. The mode also decides which saved status word is read or written. Storage is 31 general registers, including the program counter, plus six status words: one current word and five saved words.

Two read ports return data in the same cycle as the address. One write port updates the register on the clock edge. Reading index 15 gives the program counter plus the pipeline look-ahead. Writing index 15 is flagged as a branch on the same cycle. The status words have their own write strobes. Decode, the ALU and pipeline control sit outside this block.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every general register reads zero and `cpsr_o` equals 0x000000D3: mode field supervisor, bits 7 and 6 set, bit 5 clear.
- R2: The mode is `cpsr_o[4:0]`. The encodings are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other encoding selects the same registers as user mode.
- R3: Indices 0 to 7 have one physical copy that all modes share. Indices 8 to 12 have one copy shared by all modes except fast interrupt mode, which has a private copy of those five.
- R4: Indices 13 and 14 have six physical copies: one shared by user and system, and one each for fast interrupt, interrupt, supervisor, abort and undefined.
- R5: Both read ports are combinational. When an index is read and written in the same cycle, the read returns the old value before the edge and the new value after it.
- R6: A read of index 15 returns the stored program counter plus 8 when `cpsr_o[5]` is 0, and plus 4 when it is 1. `pc_o` shows the stored value unmodified.
- R7: `branch_o` is high in exactly the cycles where a write to index 15 is presented. `pc_o` takes the written value at the next edge. Writes to other indices leave `pc_o` unchanged.
- R8: When `cpsr_we_i` is high, `cpsr_o` takes `cpsr_wdata_i` at the next edge, and register steering follows the new mode from then on.
- R9: Each of the five exception modes has its own saved status word. It is written through `spsr_we_i` while that mode is current, and it is seen on `spsr_o` only in that mode.
- R10: In user, system or unlisted modes, `spsr_we_i` is ignored and none of the saved words changes. In those modes `spsr_o` returns `cpsr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raddr_a_i | input | 4 | Read port A register index |
| rdata_a_o | output | 32 | Read port A data |
| raddr_b_i | input | 4 | Read port B register index |
| rdata_b_o | output | 32 | Read port B data |
| we_i | input | 1 | General register write enable |
| waddr_i | input | 4 | Write register index |
| wdata_i | input | 32 | Write data |
| pc_o | output | 32 | Stored program counter |
| branch_o | output | 1 | High when index 15 is being written |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wdata_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_we_i | input | 1 | Saved status write enable for the current mode |
| spsr_wdata_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status of the current mode, or the current status in unbanked modes |

## Verification
The bench fills every banked copy with a distinct value and then reads each one back from every mode. A design that steers an index to the wrong copy returns another mode's value. In particular, a design that gives system mode its own stack copy, or that lets fast interrupt mode share indices 8 to 12, is caught this way. Index 15 is read in both instruction widths, so a missing or fixed look-ahead offset shows up, and a write to 15 is checked for the branch flag.

The bench also writes a saved status word while in user mode and then confirms that all five exception copies are unchanged. It reads an index in the same cycle it is written, which exposes write-through forwarding. Finally, it selects an unlisted mode encoding, which must fall back to user behaviour.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
package bank_pkg;
  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam int unsigned NUM_LOGICAL = 16;
  localparam int unsigned FIQ_LO_BASE = 16;  // private copies of 8..12
  localparam int unsigned NUM_FIQ_LO  = 5;
  localparam int unsigned SP_LR_BASE  = FIQ_LO_BASE + NUM_FIQ_LO;
  localparam int unsigned NUM_XBANKS  = 5;
  localparam int unsigned NUM_PHYS    = SP_LR_BASE + 2 * NUM_XBANKS;
  localparam int unsigned PHYS_W      = $clog2(NUM_PHYS);
  localparam int unsigned T_BIT       = 5;
  localparam logic [31:0] CPSR_RESET  = 32'h0000_00D3;

  function automatic bank_e mode_to_bank(input logic [4:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_USR;
    endcase
  endfunction
endpackage

// File: rtl/bank_map.sv
`timescale 1ns/1ps
module bank_map
  import bank_pkg::*;
(
  input  logic [3:0]        idx_i,
  input  bank_e             bank_i,
  output logic [PHYS_W-1:0] phys_o
);
  logic lo_fiq, sp_lr;

  assign lo_fiq = (idx_i >= 4'd8) && (idx_i <= 4'd12) && (bank_i == BK_FIQ);
  assign sp_lr  = (idx_i == 4'd13 || idx_i == 4'd14) && (bank_i != BK_USR);

  always_comb begin
    phys_o = PHYS_W'(idx_i);
    if (lo_fiq)
      phys_o = PHYS_W'(FIQ_LO_BASE) + PHYS_W'(idx_i - 4'd8);
    else if (sp_lr)
      phys_o = PHYS_W'(SP_LR_BASE)
             + PHYS_W'({3'(bank_i) - 3'd1, 1'b0})
             + PHYS_W'(idx_i == 4'd14);
  end

  always_comb begin
    a_r4_in_range: assert (phys_o < PHYS_W'(NUM_PHYS));
  end
endmodule

// File: rtl/psr_store.sv
`timescale 1ns/1ps
module psr_store
  import bank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bank_e             bank_i,
  input  logic              cpsr_we_i,
  input  logic [DATA_W-1:0] cpsr_wdata_i,
  input  logic              spsr_we_i,
  input  logic [DATA_W-1:0] spsr_wdata_i,
  output logic [DATA_W-1:0] cpsr_o,
  output logic [DATA_W-1:0] spsr_o
);
  localparam int unsigned SLOT_W = $clog2(NUM_XBANKS);

  logic [DATA_W-1:0]                 cpsr_q;
  logic [NUM_XBANKS-1:0][DATA_W-1:0] spsr_q;
  logic                              has_spsr;
  logic [SLOT_W-1:0]                 slot;

  assign has_spsr = (bank_i != BK_USR);
  assign slot     = SLOT_W'(3'(bank_i) - 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q <= DATA_W'(CPSR_RESET);
      spsr_q <= '0;
    end else begin
      if (cpsr_we_i) cpsr_q <= cpsr_wdata_i;
      if (spsr_we_i && has_spsr) spsr_q[slot] <= spsr_wdata_i;
    end
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = has_spsr ? spsr_q[slot] : cpsr_q;

  a_r8_cpsr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_we_i |=> cpsr_o == $past(cpsr_wdata_i));
  a_r9_spsr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spsr_we_i && has_spsr && !cpsr_we_i) |=> spsr_o == $past(spsr_wdata_i));
  a_r10_spsr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_spsr |=> $stable(spsr_q));
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
  import bank_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned PC_ADV_WIDE  = 8,
  parameter int unsigned PC_ADV_SHORT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [3:0]        raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  input  logic              we_i,
  input  logic [3:0]        waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] pc_o,
  output logic              branch_o,
  input  logic              cpsr_we_i,
  input  logic [DATA_W-1:0] cpsr_wdata_i,
  output logic [DATA_W-1:0] cpsr_o,
  input  logic              spsr_we_i,
  input  logic [DATA_W-1:0] spsr_wdata_i,
  output logic [DATA_W-1:0] spsr_o
);
  localparam int unsigned NUM_RD = 2;
  localparam logic [3:0]  PC_IDX = 4'd15;

  logic [NUM_PHYS-1:0][DATA_W-1:0] gpr_q;
  bank_e                           bank;
  logic [PHYS_W-1:0]               wphys;
  logic [NUM_RD-1:0][3:0]          raddr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rdata;
  logic [DATA_W-1:0]               pc_adv;

  assign bank   = mode_to_bank(cpsr_o[4:0]);
  assign raddr  = {raddr_b_i, raddr_a_i};
  assign pc_adv = cpsr_o[T_BIT] ? DATA_W'(PC_ADV_SHORT) : DATA_W'(PC_ADV_WIDE);

  bank_map u_wmap (.idx_i(waddr_i), .bank_i(bank), .phys_o(wphys));

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [PHYS_W-1:0] rphys;
    bank_map u_rmap (.idx_i(raddr[p]), .bank_i(bank), .phys_o(rphys));
    assign rdata[p] = (raddr[p] == PC_IDX) ? gpr_q[PC_IDX] + pc_adv
                                           : gpr_q[rphys];
  end

  assign rdata_a_o = rdata[0];
  assign rdata_b_o = rdata[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gpr_q <= '0;
    else if (we_i) gpr_q[wphys] <= wdata_i;
  end

  assign pc_o     = gpr_q[PC_IDX];
  assign branch_o = we_i && (waddr_i == PC_IDX);

  psr_store #(.DATA_W(DATA_W)) u_psr (
    .clk_i, .rst_ni, .bank_i(bank),
    .cpsr_we_i, .cpsr_wdata_i, .spsr_we_i, .spsr_wdata_i,
    .cpsr_o, .spsr_o
  );

  a_r7_branch_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o |=> pc_o == $past(wdata_i));
  a_r7_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && waddr_i == PC_IDX) |=> $stable(pc_o));
  a_r5_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != PC_IDX && raddr_a_i == waddr_i && !cpsr_we_i)
      |=> (raddr_a_i != $past(raddr_a_i)) || rdata_a_o == $past(wdata_i));
endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  raddr_a = '0, raddr_b = '0, waddr = '0;
  logic [31:0] rdata_a, rdata_b, wdata = '0, pc, cpsr, spsr;
  logic [31:0] cpsr_wdata = '0, spsr_wdata = '0;
  logic        we = 1'b0, branch, cpsr_we = 1'b0, spsr_we = 1'b0;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111, M_BAD = 5'b10100;

  always #2.5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .raddr_a_i(raddr_a), .rdata_a_o(rdata_a),
    .raddr_b_i(raddr_b), .rdata_b_o(rdata_b),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .pc_o(pc), .branch_o(branch),
    .cpsr_we_i(cpsr_we), .cpsr_wdata_i(cpsr_wdata), .cpsr_o(cpsr),
    .spsr_we_i(spsr_we), .spsr_wdata_i(spsr_wdata), .spsr_o(spsr)
  );

  function automatic logic [31:0] psr(input logic [4:0] m, input logic t);
    return {24'h0, 2'b11, t, m};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk); we = 1'b1; waddr = idx; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk); raddr_a = idx; #1; d = rdata_a;
  endtask

  task automatic set_cpsr(input logic [31:0] v);
    @(negedge clk); cpsr_we = 1'b1; cpsr_wdata = v;
    @(negedge clk); cpsr_we = 1'b0;
  endtask

  task automatic wr_spsr(input logic [31:0] v);
    @(negedge clk); spsr_we = 1'b1; spsr_wdata = v;
    @(negedge clk); spsr_we = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 cpsr", cpsr, 32'h0000_00D3);
    check("R1 pc", pc, 32'h0);
    for (int i = 0; i < 15; i++) begin
      rd(4'(i), d); check("R1 gpr", d, 32'h0);
    end
  endtask

  task automatic t_shared_low;
    logic [31:0] d;
    for (int i = 0; i < 13; i++) wr(4'(i), 32'h1000_0000 + 32'(i));
    set_cpsr(psr(M_USR, 1'b0));
    for (int i = 0; i < 13; i++) begin
      rd(4'(i), d); check("R3 usr sees shared", d, 32'h1000_0000 + 32'(i));
    end
    set_cpsr(psr(M_IRQ, 1'b0));
    for (int i = 0; i < 13; i++) begin
      rd(4'(i), d); check("R3 irq sees shared", d, 32'h1000_0000 + 32'(i));
    end
  endtask

  task automatic t_fiq_low;
    logic [31:0] d;
    set_cpsr(psr(M_FIQ, 1'b0));
    for (int i = 8; i < 13; i++) wr(4'(i), 32'hF100_0000 + 32'(i));
    for (int i = 0; i < 13; i++) begin
      rd(4'(i), d);
      check("R3 fiq view", d, (i < 8) ? 32'h1000_0000 + 32'(i) : 32'hF100_0000 + 32'(i));
    end
    set_cpsr(psr(M_SVC, 1'b0));
    for (int i = 8; i < 13; i++) begin
      rd(4'(i), d); check("R3 svc untouched by fiq", d, 32'h1000_0000 + 32'(i));
    end
  endtask

  task automatic t_sp_lr;
    logic [4:0]  modes[6] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
    logic [31:0] d;
    for (int k = 0; k < 6; k++) begin
      set_cpsr(psr(modes[k], 1'b0));
      wr(4'd13, 32'hA000_0D00 + 32'(k));
      wr(4'd14, 32'hA000_0E00 + 32'(k));
    end
    for (int k = 0; k < 6; k++) begin
      set_cpsr(psr(modes[k], 1'b0));
      rd(4'd13, d); check("R4 sp copy", d, 32'hA000_0D00 + 32'(k));
      rd(4'd14, d); check("R4 lr copy", d, 32'hA000_0E00 + 32'(k));
    end
    set_cpsr(psr(M_SYS, 1'b0));
    rd(4'd13, d); check("R4 sys shares usr sp", d, 32'hA000_0D00);
    rd(4'd14, d); check("R4 sys shares usr lr", d, 32'hA000_0E00);
    set_cpsr(psr(M_BAD, 1'b0));
    rd(4'd13, d); check("R2 unlisted mode as usr", d, 32'hA000_0D00);
    check("R2 unlisted mode spsr", spsr, psr(M_BAD, 1'b0));
  endtask

  task automatic t_pc;
    logic [31:0] d;
    set_cpsr(psr(M_SVC, 1'b0));
    @(negedge clk); we = 1'b1; waddr = 4'd15; wdata = 32'h0000_1000;
    #1; check("R7 branch flag", {31'h0, branch}, 32'h1);
    check("R7 pc before edge", pc, 32'h0);
    @(negedge clk); we = 1'b0;
    #1; check("R7 branch drops", {31'h0, branch}, 32'h0);
    check("R7 pc after edge", pc, 32'h0000_1000);
    wr(4'd2, 32'h2222_2222);
    check("R7 pc unchanged by other write", pc, 32'h0000_1000);
    @(negedge clk); raddr_b = 4'd15; #1;
    check("R6 pc read wide", rdata_b, 32'h0000_1008);
    set_cpsr(psr(M_SVC, 1'b1));
    @(negedge clk); raddr_b = 4'd15; #1;
    check("R6 pc read short", rdata_b, 32'h0000_1004);
    check("R6 pc_o raw", pc, 32'h0000_1000);
    set_cpsr(psr(M_SVC, 1'b0));
  endtask

  task automatic t_rw_same;
    @(negedge clk); raddr_a = 4'd3; we = 1'b1; waddr = 4'd3; wdata = 32'h3333_BEEF;
    #1; check("R5 old value same cycle", rdata_a, 32'h1000_0003);
    @(posedge clk); #1;
    check("R5 new value after edge", rdata_a, 32'h3333_BEEF);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic t_spsr;
    logic [4:0] modes[5] = '{M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
    for (int k = 0; k < 5; k++) begin
      set_cpsr(psr(modes[k], 1'b0));
      check("R8 cpsr write", cpsr, psr(modes[k], 1'b0));
      wr_spsr(32'h5000_0000 + 32'(k));
    end
    set_cpsr(psr(M_USR, 1'b0));
    check("R10 usr spsr reads cpsr", spsr, psr(M_USR, 1'b0));
    wr_spsr(32'hDEAD_BEEF);
    check("R10 usr spsr write ignored", spsr, psr(M_USR, 1'b0));
    set_cpsr(psr(M_SYS, 1'b0));
    wr_spsr(32'hCAFE_F00D);
    check("R10 sys spsr reads cpsr", spsr, psr(M_SYS, 1'b0));
    for (int k = 0; k < 5; k++) begin
      set_cpsr(psr(modes[k], 1'b0));
      check("R9 R10 spsr copy intact", spsr, 32'h5000_0000 + 32'(k));
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    t_reset();
    t_shared_low();
    t_fiq_low();
    t_sp_lr();
    t_pc();
    t_rw_same();
    t_spsr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule